// File: doc/BRIEF.md
# Sub-Audio Squelch Tone Generator

This block synthesises the continuous sub-audio tone that a transmitter adds under speech for tone-coded squelch. A phase accumulator advances once per 1 MHz reference tick. The top bits of the phase address a quarter-wave sine table, which produces a signed sample stream for a downstream DAC. A 6-bit code picks one of 39 standard tone frequencies between 67.0 Hz and 250.3 Hz. Any other code means "no tone".

The block drives a tone only in transmit mode with a valid code. In transmit mode with the no-tone code it still drives its output, but holds the sample at mid-scale bias (zero). In receive mode it releases the output through its enable, which the pad logic uses as a high-impedance request. In transmit mode the reverse input turns the waveform through half a cycle at once, which suppresses the squelch tail at the far receiver. The reversal acts only on the lookup, so the running phase is never disturbed. The accumulator clears whenever no tone is being produced, so every new tone starts at phase zero.

Top module: `ctcss_tone_gen`

## Requirements
- R1: While reset is asserted and on the first cycles after it, tone_out is 0 and tone_oe is 0.
- R2: Codes 0 to 38 select, in ascending order, 67.0, 69.3, 71.9, 74.4, 77.0, 79.7, 82.5, 85.4, 88.5, 91.5, 94.8, 97.4, 100.0, 103.5, 107.2, 110.9, 114.8, 118.8, 123.0, 127.3, 131.8, 136.5, 141.3, 146.2, 151.4, 156.7, 162.2, 167.9, 173.8, 179.9, 186.2, 192.8, 203.5, 210.7, 218.1, 225.7, 233.6, 241.8 and 250.3 Hz. Each cycle with clk_en high adds round(f * 2^24 / 1e6) to the 24-bit phase, modulo 2^24, which keeps every tone within 0.3 % of nominal.
- R3: While a tone is active, tone_out one clock later equals round(32767 * sin(2*pi*(p + 0.5)/1024)) within 2 LSB. Here p is bits 23..14 of the phase in effect for the lookup.
- R4: In transmit mode (rx_mode = 0), a code from 39 to 63 gives tone_oe = 1 and tone_out = 0 on the next clock.
- R5: With rx_mode = 1, the next clock gives tone_oe = 0 and tone_out = 0.
- R6: In transmit mode, ptl = 1 adds half a cycle to the lookup phase, so tone_out becomes the negative of the unreversed sample on the next clock. The accumulator is not changed.
- R7: In receive mode, ptl has no effect on tone_out or tone_oe.
- R8: With clk_en low and the inputs held, the phase holds and tone_out stays constant.
- R9: When no tone is being produced, the phase clears to 0. The first sample after a tone starts corresponds to phase 0.
- R10: A change between two valid codes keeps the accumulated phase, and the accumulator continues with the new increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | 1 MHz reference tick; one phase step per high cycle |
| tone_code | input | 6 | Tone select; 0 to 38 valid, others mean no tone |
| rx_mode | input | 1 | 1 = receive (output released), 0 = transmit |
| ptl | input | 1 | Phase reverse in transmit mode; ignored in receive |
| tone_out | output | 16 | Signed sine sample, 0 = bias |
| tone_oe | output | 1 | Output drive enable; 0 requests high impedance |

## Verification
The critical coincidence is a phase reversal that lands in the same cycle as a reference tick. In that cycle the lookup uses the pre-tick phase with half a cycle added, while the accumulator steps forward untouched. The bench raises ptl and clk_en on the same edge. It expects the negated sample of the old phase first, then the negated sample of the advanced phase, and then, after ptl drops, the plain sample at that same advanced phase. A second coincidence, a code change next to a tick, is judged by the accumulated phase after the switch matching the sum of both increments.

// File: rtl/ctcss_pkg.sv
package ctcss_pkg;

    localparam int NUM_TONES = 39;
    localparam longint PI_Q30 = 64'd3373259426;

    // Tone frequency in tenths of a hertz, ascending by code.
    function automatic int tone_dhz(int idx);
        case (idx)
            0:  return 670;   1:  return 693;   2:  return 719;   3:  return 744;
            4:  return 770;   5:  return 797;   6:  return 825;   7:  return 854;
            8:  return 885;   9:  return 915;   10: return 948;   11: return 974;
            12: return 1000;  13: return 1035;  14: return 1072;  15: return 1109;
            16: return 1148;  17: return 1188;  18: return 1230;  19: return 1273;
            20: return 1318;  21: return 1365;  22: return 1413;  23: return 1462;
            24: return 1514;  25: return 1567;  26: return 1622;  27: return 1679;
            28: return 1738;  29: return 1799;  30: return 1862;  31: return 1928;
            32: return 2035;  33: return 2107;  34: return 2181;  35: return 2257;
            36: return 2336;  37: return 2418;  38: return 2503;
            default: return 0;
        endcase
    endfunction

    // Phase step per reference tick: round(f * 2^acc_w / clk_hz).
    function automatic longint tone_inc(int idx, int acc_w, int clk_hz);
        longint num;
        num = longint'(tone_dhz(idx)) <<< acc_w;
        return (num + longint'(5) * longint'(clk_hz)) / (longint'(10) * longint'(clk_hz));
    endfunction

    // Quarter-wave sample at the midpoint of step idx, via Taylor series in Q30.
    function automatic int quarter_sine(int idx, int aw, int amp);
        longint x, x2, term, sum;
        x    = (longint'(2 * idx + 1) * PI_Q30) >>> (aw + 2);
        x2   = (x * x) >>> 30;
        term = x;
        sum  = x;
        for (int k = 1; k <= 6; k++) begin
            term = -((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1));
            sum  = sum + term;
        end
        return int'((sum * longint'(amp) + (longint'(1) <<< 29)) >>> 30);
    endfunction

endpackage

// File: rtl/ctcss_tone_rom.sv
module ctcss_tone_rom
    import ctcss_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int ACC_W  = 24,
    parameter int CLK_HZ = 1000000
) (
    input  logic [CODE_W-1:0] code,
    output logic [ACC_W-1:0]  inc,
    output logic              valid
);
    localparam int CODE_N = 1 << CODE_W;

    logic [ACC_W-1:0] inc_tab [CODE_N];
    logic [CODE_N-1:0] ok_tab;

    for (genvar g = 0; g < CODE_N; g++) begin : g_entry
        if (g < NUM_TONES) begin : g_tone
            assign inc_tab[g] = ACC_W'(tone_inc(g, ACC_W, CLK_HZ));
            assign ok_tab[g]  = 1'b1;
        end else begin : g_none
            assign inc_tab[g] = '0;
            assign ok_tab[g]  = 1'b0;
        end
    end

    assign inc   = inc_tab[code];
    assign valid = ok_tab[code];
endmodule

// File: rtl/ctcss_sine_lut.sv
module ctcss_sine_lut
    import ctcss_pkg::*;
#(
    parameter int LUT_AW = 8,
    parameter int SAMP_W = 16
) (
    input  logic [LUT_AW+1:0]         phase,
    output logic signed [SAMP_W-1:0]  sample
);
    localparam int DEPTH = 1 << LUT_AW;
    localparam int MAG_W = SAMP_W - 1;
    localparam int AMP   = (1 << MAG_W) - 1;

    logic [MAG_W-1:0] qrom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_q
        assign qrom[g] = MAG_W'(quarter_sine(g, LUT_AW, AMP));
    end

    logic [1:0]        quad;
    logic [LUT_AW-1:0] addr;
    logic [MAG_W-1:0]  mag;
    logic signed [SAMP_W-1:0] mag_s;

    always_comb begin
        quad   = phase[LUT_AW+1:LUT_AW];
        addr   = quad[0] ? ~phase[LUT_AW-1:0] : phase[LUT_AW-1:0];
        mag    = qrom[addr];
        mag_s  = $signed({1'b0, mag});
        sample = quad[1] ? -mag_s : mag_s;
    end
endmodule

// File: rtl/ctcss_tone_gen.sv
module ctcss_tone_gen
    import ctcss_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int ACC_W  = 24,
    parameter int LUT_AW = 8,
    parameter int SAMP_W = 16,
    parameter int CLK_HZ = 1000000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clk_en,
    input  logic [CODE_W-1:0]        tone_code,
    input  logic                     rx_mode,
    input  logic                     ptl,
    output logic signed [SAMP_W-1:0] tone_out,
    output logic                     tone_oe
);
    localparam int PH_W = LUT_AW + 2;

    typedef struct packed {
        logic [ACC_W-1:0]         acc;
        logic signed [SAMP_W-1:0] smp;
        logic                     oe;
    } gen_t;

    gen_t st_d, st_q;

    logic [ACC_W-1:0]  step;
    logic              code_ok;
    logic              tone_on;
    logic [PH_W-1:0]   look_ph;
    logic signed [SAMP_W-1:0] lut_val;

    ctcss_tone_rom #(
        .CODE_W(CODE_W), .ACC_W(ACC_W), .CLK_HZ(CLK_HZ)
    ) u_rom (
        .code(tone_code), .inc(step), .valid(code_ok)
    );

    // Half-cycle reversal = flip the top phase bit used for lookup only.
    assign look_ph = st_q.acc[ACC_W-1 -: PH_W] ^ {ptl, {(PH_W-1){1'b0}}};

    ctcss_sine_lut #(
        .LUT_AW(LUT_AW), .SAMP_W(SAMP_W)
    ) u_lut (
        .phase(look_ph), .sample(lut_val)
    );

    always_comb begin
        tone_on = !rx_mode && code_ok;
        st_d    = st_q;
        if (!tone_on) begin
            st_d.acc = '0;
        end else if (clk_en) begin
            st_d.acc = st_q.acc + step;
        end
        st_d.smp = tone_on ? lut_val : '0;
        st_d.oe  = !rx_mode;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tone_out = st_q.smp;
    assign tone_oe  = st_q.oe;
endmodule

// File: rtl/ctcss_tone_gen_chk.sv
module ctcss_tone_gen_chk #(
    parameter int CODE_W = 6,
    parameter int SAMP_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     clk_en,
    input logic [CODE_W-1:0]        tone_code,
    input logic                     rx_mode,
    input logic                     ptl,
    input logic signed [SAMP_W-1:0] tone_out,
    input logic                     tone_oe
);
    localparam logic [CODE_W-1:0] FIRST_BAD = CODE_W'(39);

    logic [1:0] warm_q;
    logic       active;

    always_ff @(posedge clk) begin
        if (!rst_n)              warm_q <= 2'd0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    assign active = !rx_mode && (tone_code < FIRST_BAD);

    // R5
    rx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_mode |=> (!tone_oe && tone_out == '0));

    // R4
    notone_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_mode && tone_code >= FIRST_BAD) |=> (tone_oe && tone_out == '0));

    // R6
    reverse_negates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q[1] && active && $past(active) && !$past(clk_en) && ptl != $past(ptl))
        |=> ($signed(tone_out) == -$signed($past(tone_out))));

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q[1] && active && $past(active) && !$past(clk_en) && ptl == $past(ptl))
        |=> $stable(tone_out));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (tone_out == '0 && !tone_oe));
endmodule

bind ctcss_tone_gen ctcss_tone_gen_chk #(
    .CODE_W(CODE_W), .SAMP_W(SAMP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .tone_code(tone_code),
    .rx_mode(rx_mode), .ptl(ptl), .tone_out(tone_out), .tone_oe(tone_oe)
);

// File: tb/ctcss_tone_gen_test.sv
`timescale 1ns/1ps
module ctcss_tone_gen_test;
    localparam real PI = 3.14159265358979;
    localparam longint MASK = 64'hFFFFFF;

    logic clk = 1'b0, rst_n = 1'b0, clk_en = 1'b0, rx_mode = 1'b1, ptl = 1'b0;
    logic [5:0] tone_code = 6'd0;
    logic signed [15:0] tone_out;
    logic tone_oe;

    int checks = 0, failures = 0;
    longint model_acc = 0;

    real TONES [39] = '{67.0, 69.3, 71.9, 74.4, 77.0, 79.7, 82.5, 85.4, 88.5, 91.5,
                        94.8, 97.4, 100.0, 103.5, 107.2, 110.9, 114.8, 118.8, 123.0,
                        127.3, 131.8, 136.5, 141.3, 146.2, 151.4, 156.7, 162.2, 167.9,
                        173.8, 179.9, 186.2, 192.8, 203.5, 210.7, 218.1, 225.7, 233.6,
                        241.8, 250.3};

    always #2.5 clk = ~clk;

    ctcss_tone_gen uut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .tone_code(tone_code),
        .rx_mode(rx_mode), .ptl(ptl), .tone_out(tone_out), .tone_oe(tone_oe)
    );

    function automatic longint inc_of(int c);
        return longint'($rtoi(TONES[c] * 16777216.0 / 1.0e6 + 0.5));
    endfunction

    function automatic real ideal(longint acc, bit rev);
        longint ph;
        ph = ((acc + (rev ? 64'd8388608 : 64'd0)) >> 14) & 64'd1023;
        return 32767.0 * $sin(2.0 * PI * ($itor(ph) + 0.5) / 1024.0);
    endfunction

    task automatic check_near(string req, real exp);
        real d;
        checks++;
        d = $itor(tone_out) - exp;
        if (d < 0.0) d = -d;
        if (d > 2.0) begin
            failures++;
            $display("FAIL %s: tone_out=%0d expected=%0.2f", req, tone_out, exp);
        end
    endtask

    task automatic check_port(string req, int act_smp, int exp_smp, logic act_oe, logic exp_oe);
        checks++;
        if (act_smp != exp_smp || act_oe !== exp_oe) begin
            failures++;
            $display("FAIL %s: tone_out=%0d oe=%0b expected tone_out=%0d oe=%0b",
                     req, act_smp, act_oe, exp_smp, exp_oe);
        end
    endtask

    task automatic advance(int n);
        clk_en = 1'b1;
        repeat (n) @(negedge clk);
        clk_en = 1'b0;
        @(negedge clk);
        model_acc = (model_acc + longint'(n) * inc_of(int'(tone_code))) & MASK;
    endtask

    task automatic go_idle();
        rx_mode = 1'b1; ptl = 1'b0; clk_en = 1'b0;
        @(negedge clk);
        model_acc = 0;
    endtask

    task automatic start_tx(int code);
        rx_mode = 1'b0; tone_code = 6'(code);
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check_port("R1 in reset", int'(tone_out), 0, tone_oe, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_port("R1 after reset", int'(tone_out), 0, tone_oe, 1'b0);
    endtask

    task automatic t_tone(int code, int n1, int n2, int n3);
        go_idle();
        start_tx(code);
        check_near("R9 start at phase 0", ideal(0, 1'b0));
        check_port("R2 tx enable", 0, 0, tone_oe, 1'b1);
        advance(n1); check_near("R2/R3 tone a", ideal(model_acc, 1'b0));
        advance(n2); check_near("R2/R3 tone b", ideal(model_acc, 1'b0));
        advance(n3); check_near("R2/R3 tone c", ideal(model_acc, 1'b0));
    endtask

    task automatic t_hold();
        repeat (4) @(negedge clk);
        check_near("R8 hold", ideal(model_acc, 1'b0));
    endtask

    task automatic t_reverse();
        go_idle();
        start_tx(12);
        advance(777);
        check_near("R6 before reverse", ideal(model_acc, 1'b0));
        ptl = 1'b1;
        @(negedge clk);
        check_near("R6 reversed", ideal(model_acc, 1'b1));
        ptl = 1'b0;
        @(negedge clk);
        check_near("R6 restored, phase untouched", ideal(model_acc, 1'b0));
        // reversal coincident with a tick
        ptl = 1'b1; clk_en = 1'b1;
        @(negedge clk);
        check_near("R6 reverse with tick, old phase", ideal(model_acc, 1'b1));
        model_acc = (model_acc + inc_of(12)) & MASK;
        clk_en = 1'b0;
        @(negedge clk);
        check_near("R6 reverse with tick, new phase", ideal(model_acc, 1'b1));
        ptl = 1'b0;
        @(negedge clk);
        check_near("R6 after coincident reverse", ideal(model_acc, 1'b0));
        advance(1234);
        check_near("R6 accumulator continues", ideal(model_acc, 1'b0));
    endtask

    task automatic t_notone();
        go_idle();
        start_tx(39);
        clk_en = 1'b1;
        repeat (10) @(negedge clk);
        check_port("R4 code 39", int'(tone_out), 0, tone_oe, 1'b1);
        tone_code = 6'd63;
        repeat (2) @(negedge clk);
        check_port("R4 code 63", int'(tone_out), 0, tone_oe, 1'b1);
        clk_en = 1'b0;
        tone_code = 6'd20;
        @(negedge clk);
        model_acc = 0;
        check_near("R9 restart after no-tone", ideal(0, 1'b0));
    endtask

    task automatic t_rx();
        go_idle();
        start_tx(5);
        advance(300);
        rx_mode = 1'b1;
        @(negedge clk);
        check_port("R5 rx released", int'(tone_out), 0, tone_oe, 1'b0);
        ptl = 1'b1; clk_en = 1'b1;
        repeat (3) @(negedge clk);
        check_port("R7 ptl in rx", int'(tone_out), 0, tone_oe, 1'b0);
        clk_en = 1'b0; ptl = 1'b0;
        rx_mode = 1'b0;
        @(negedge clk);
        model_acc = 0;
        check_near("R9 restart after rx", ideal(0, 1'b0));
    endtask

    task automatic t_switch();
        go_idle();
        start_tx(0);
        advance(500);
        check_near("R10 before switch", ideal(model_acc, 1'b0));
        tone_code = 6'd38;
        advance(500);
        check_near("R10 after switch", ideal(model_acc, 1'b0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_tone(0, 1000, 4321, 9000);
        t_hold();
        t_tone(12, 2500, 777, 6000);
        t_tone(38, 333, 5000, 1999);
        t_tone(27, 4100, 123, 3000);
        t_reverse();
        t_notone();
        t_rx();
        t_switch();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule